// File: doc/BRIEF.md
# Closed Caption Line Inserter

This block puts caption character pairs onto the caption lines of an interlaced 525-line frame. Software writes one pair of 7-bit characters for each field through a small write port. The timing core marks the start of every line and gives the line number and field parity. On a caption line that the field-select control allows, the block sends a serial frame: a clock run-in, a start code, then the two characters, each with an odd-parity bit added.

The store holds one pair per field, and each pair is only one entry deep. A pair armed by a write goes out on the very next eligible line of its field, with no frame of latency. Once that pair has been sent, the field carries null characters until software arms it again. Writes that arrive while a line is being sent wait in a holding slot until the line ends, so the bits in flight never change.

The output is a paced bit stream with a per-bit valid. It has no back-pressure: the line timing fixes the bit rate, so the consumer must accept each bit while `out_valid` is high. Each bit is held for a programmable number of clocks.

Top module: `cc_line_inserter`

## Requirements
- R1: While `cfg_enable` is low at a line start, no frame is sent on that line (`out_valid` stays low).
- R2: A frame is sent only on a line start with `line_num == ODD_LINE` and `field_even == 0`, or with `line_num == EVEN_LINE` and `field_even == 1`. Every other line/field combination sends nothing.
- R3: The field-select encoding is as follows. Value 00 sends on no field, 01 on the odd field only, 10 on the even field only, and 11 on both. Bit 0 gates the odd field and bit 1 gates the even field.
- R4: A frame is 26 bits, sent in this order:
  - seven run-in bits 1,0,1,0,1,0,1;
  - start code 0,0,1;
  - character 1 as eight bits, LSB first;
  - character 2 as eight bits, LSB first.
- R5: Bit 7 of each sent character is odd parity over its bits 6:0. Bit 7 of `wr_data` is ignored.
- R6: Each bit is held for `cfg_clks_per_bit` clocks, and a value of 0 counts as 1.
  - `out_valid` is high for exactly 26 times that many consecutive cycles.
  - It rises in the cycle after the clock edge that samples the line start.
- R7: The write addresses are: 0 = odd char 1, 1 = odd char 2, 2 = even char 1, 3 = even char 2.
  - A write to address 1 or 3 arms that field's pair.
  - A write to address 0 or 2 only stores the character and does not arm the pair.
- R8: An armed pair is sent on the next eligible line of its own field. After it has been sent, that field sends 0x80 0x80 until it is armed again.
- R9: A write that arrives while a frame is being sent does not alter that frame. It takes effect in the first idle cycle after the line ends.
- R10: A line start that arrives while a frame is being sent is ignored.
- R11: After reset, `out_valid` is low and no pair is armed, so the first eligible line sends nulls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle pulse at the start of each line |
| line_num | input | LINE_W | Current line number |
| field_even | input | 1 | 1 while the even field is current |
| cfg_enable | input | 1 | Caption generation on |
| cfg_field_sel | input | 2 | Field select (bit 0 odd, bit 1 even) |
| cfg_clks_per_bit | input | DIV_W | Clocks per sent bit |
| wr_en | input | 1 | Character write strobe |
| wr_addr | input | 2 | Character slot address |
| wr_data | input | 8 | Character; bit 7 ignored |
| out_valid | output | 1 | Stream bit valid |
| out_bit | output | 1 | Stream bit value |

## Verification
The bench builds the block with a 5-bit line number, `ODD_LINE = 7` and `EVEN_LINE = 12`. With these values it can sweep every line number against both fields, all four field-select codes and both enable states, which puts the whole gating decision within reach. It also runs all 128 characters through both character positions, and sweeps the bit divider from 0 to 5. Writes and line starts are injected in the middle of a frame to reach the holding and ignore paths.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int FRAME_BITS = 26;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam logic [6:0] RUNIN = 7'b1010101;  // sent bit 0 first
  localparam logic [2:0] START = 3'b100;      // sent 0,0,1

  function automatic logic [7:0] with_parity(input logic [6:0] c);
    return {~^c, c};
  endfunction

  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [6:0] c1,
                                                         input logic [6:0] c2);
    return {with_parity(c2), with_parity(c1), START, RUNIN};
  endfunction
endpackage

// File: rtl/cc_field_arbiter.sv
module cc_field_arbiter #(
  parameter int LINE_W    = 9,
  parameter int ODD_LINE  = 21,
  parameter int EVEN_LINE = 284
) (
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_even,
  input  logic              cfg_enable,
  input  logic [1:0]        cfg_field_sel,
  input  logic              busy,
  output logic              go,
  output logic              go_even
);
  localparam logic [LINE_W-1:0] ODD_L  = LINE_W'(ODD_LINE);
  localparam logic [LINE_W-1:0] EVEN_L = LINE_W'(EVEN_LINE);

  logic odd_hit, even_hit;

  always_comb begin
    odd_hit  = !field_even && (line_num == ODD_L)  && cfg_field_sel[0];
    even_hit =  field_even && (line_num == EVEN_L) && cfg_field_sel[1];
    go       = line_start && !busy && cfg_enable && (odd_hit || even_hit);
    go_even  = field_even;
  end
endmodule

// File: rtl/cc_pair_store.sv
module cc_pair_store (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       busy,
  input  logic       consume,
  input  logic       sel_even,
  output logic [6:0] tx_c1,
  output logic [6:0] tx_c2
);
  localparam int SLOTS = 4;

  logic [6:0] chr    [SLOTS];
  logic [6:0] hold_d [SLOTS];
  logic [SLOTS-1:0] hold_v;
  logic [SLOTS-1:0] direct;
  logic [SLOTS-1:0] apply;
  logic [1:0] armed;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_comb begin
      direct[i] = wr_en && (wr_addr == 2'(i)) && !busy;
      apply[i]  = direct[i] || (hold_v[i] && !busy);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        chr[i]    <= '0;
        hold_v[i] <= 1'b0;
        hold_d[i] <= '0;
      end else begin
        if (direct[i])
          chr[i] <= wr_data[6:0];
        else if (hold_v[i] && !busy)
          chr[i] <= hold_d[i];
        if (wr_en && (wr_addr == 2'(i)) && busy) begin
          hold_v[i] <= 1'b1;
          hold_d[i] <= wr_data[6:0];
        end else if (!busy) begin
          hold_v[i] <= 1'b0;
        end
      end
    end
  end

  for (genvar f = 0; f < 2; f++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rst_n)
        armed[f] <= 1'b0;
      else if (apply[2*f+1])
        armed[f] <= 1'b1;
      else if (consume && (sel_even == f[0]))
        armed[f] <= 1'b0;
    end
  end

  always_comb begin
    if (sel_even) begin
      tx_c1 = armed[1] ? chr[2] : 7'd0;
      tx_c2 = armed[1] ? chr[3] : 7'd0;
    end else begin
      tx_c1 = armed[0] ? chr[0] : 7'd0;
      tx_c2 = armed[0] ? chr[1] : 7'd0;
    end
  end
endmodule

// File: rtl/cc_bit_serializer.sv
module cc_bit_serializer
  import cc_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [6:0]       c1,
  input  logic [6:0]       c2,
  input  logic [DIV_W-1:0] clks_per_bit,
  output logic             busy,
  output logic             out_valid,
  output logic             out_bit
);
  logic [FRAME_BITS-1:0] shreg;
  logic [CNT_W-1:0]      bits_left;
  logic [DIV_W-1:0]      div_cnt;
  logic [DIV_W-1:0]      div_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      shreg     <= '0;
      bits_left <= '0;
      div_cnt   <= '0;
      div_last  <= '0;
    end else if (!busy) begin
      if (go) begin
        busy      <= 1'b1;
        shreg     <= build_frame(c1, c2);
        bits_left <= CNT_W'(FRAME_BITS - 1);
        div_cnt   <= '0;
        div_last  <= (clks_per_bit == '0) ? '0 : clks_per_bit - 1'b1;
      end
    end else if (div_cnt == div_last) begin
      div_cnt <= '0;
      if (bits_left == '0) begin
        busy <= 1'b0;
      end else begin
        shreg     <= shreg >> 1;
        bits_left <= bits_left - 1'b1;
      end
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_comb begin
    out_valid = busy;
    out_bit   = busy & shreg[0];
  end
endmodule

// File: rtl/cc_line_inserter.sv
module cc_line_inserter #(
  parameter int LINE_W    = 9,
  parameter int ODD_LINE  = 21,
  parameter int EVEN_LINE = 284,
  parameter int DIV_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [LINE_W-1:0] line_num,
  input  logic              field_even,
  input  logic              cfg_enable,
  input  logic [1:0]        cfg_field_sel,
  input  logic [DIV_W-1:0]  cfg_clks_per_bit,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [7:0]        wr_data,
  output logic              out_valid,
  output logic              out_bit
);
  logic       busy, go, go_even;
  logic [6:0] tx_c1, tx_c2;

  cc_field_arbiter #(
    .LINE_W(LINE_W), .ODD_LINE(ODD_LINE), .EVEN_LINE(EVEN_LINE)
  ) u_arb (
    .line_start(line_start), .line_num(line_num), .field_even(field_even),
    .cfg_enable(cfg_enable), .cfg_field_sel(cfg_field_sel), .busy(busy),
    .go(go), .go_even(go_even)
  );

  cc_pair_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .consume(go), .sel_even(go_even),
    .tx_c1(tx_c1), .tx_c2(tx_c2)
  );

  cc_bit_serializer #(.DIV_W(DIV_W)) u_ser (
    .clk(clk), .rst_n(rst_n), .go(go), .c1(tx_c1), .c2(tx_c2),
    .clks_per_bit(cfg_clks_per_bit), .busy(busy),
    .out_valid(out_valid), .out_bit(out_bit)
  );
endmodule

// File: rtl/cc_inserter_checker.sv
module cc_inserter_checker #(
  parameter int LINE_W    = 9,
  parameter int ODD_LINE  = 21,
  parameter int EVEN_LINE = 284
) (
  input logic              clk,
  input logic              rst_n,
  input logic              line_start,
  input logic [LINE_W-1:0] line_num,
  input logic              field_even,
  input logic              cfg_enable,
  input logic [1:0]        cfg_field_sel,
  input logic              out_valid,
  input logic              out_bit
);
  a_r1_start_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(line_start && cfg_enable));

  a_r2_caption_line_only: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past((!field_even && line_num == LINE_W'(ODD_LINE)) ||
                               (field_even && line_num == LINE_W'(EVEN_LINE))));

  a_r3_field_selected: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(field_even ? cfg_field_sel[1] : cfg_field_sel[0]));

  a_r4_runin_starts_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_bit);
endmodule

bind cc_line_inserter cc_inserter_checker #(
  .LINE_W(LINE_W), .ODD_LINE(ODD_LINE), .EVEN_LINE(EVEN_LINE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
  .field_even(field_even), .cfg_enable(cfg_enable),
  .cfg_field_sel(cfg_field_sel), .out_valid(out_valid), .out_bit(out_bit)
);

// File: tb/tb_cc_line_inserter.sv
module tb_cc_line_inserter;
  localparam int LW = 5, OL = 7, EL = 12, DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_start = 1'b0;
  logic [LW-1:0] line_num = '0;
  logic field_even = 1'b0;
  logic cfg_enable = 1'b0;
  logic [1:0] cfg_field_sel = 2'b00;
  logic [DW-1:0] cfg_clks_per_bit = 8'd1;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic out_valid, out_bit;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cc_line_inserter #(.LINE_W(LW), .ODD_LINE(OL), .EVEN_LINE(EL), .DIV_W(DW)) dut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_num(line_num),
    .field_even(field_even), .cfg_enable(cfg_enable),
    .cfg_field_sel(cfg_field_sel), .cfg_clks_per_bit(cfg_clks_per_bit),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_valid(out_valid), .out_bit(out_bit)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [25:0] exp_frame(input logic [6:0] a, input logic [6:0] b);
    logic [25:0] f = '0;
    int par;
    for (int k = 0; k < 7; k++) f[k] = (k % 2 == 0);
    f[9] = 1'b1;
    par = 1;
    for (int k = 0; k < 7; k++) begin f[10+k] = a[k]; par = par ^ a[k]; end
    f[17] = par[0];
    par = 1;
    for (int k = 0; k < 7; k++) begin f[18+k] = b[k]; par = par ^ b[k]; end
    f[25] = par[0];
    return f;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_line(input int ln, input bit ev, input int cpb,
                          output int nvalid, output logic [25:0] bits,
                          output bit hold_ok, output bit first_ok);
    bit seen_gap;
    logic last;
    nvalid = 0; bits = '0; hold_ok = 1; first_ok = 0; seen_gap = 0; last = 0;
    @(negedge clk);
    line_start = 1'b1; line_num = LW'(ln); field_even = ev;
    @(negedge clk);
    line_start = 1'b0;
    for (int i = 0; i < 26 * cpb + 3; i++) begin
      if (out_valid) begin
        if (i == 0) first_ok = 1;
        if (seen_gap) hold_ok = 0;
        if (nvalid % cpb == 0) begin
          if (nvalid / cpb < 26) bits[nvalid / cpb] = out_bit;
        end else if (out_bit !== last) hold_ok = 0;
        last = out_bit;
        nvalid++;
      end else if (nvalid > 0) seen_gap = 1;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int n;
    logic [25:0] bits;
    bit hold_ok, first_ok, elig;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R11", "out_valid in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R11", "out_valid after reset", out_valid, 0);

    cfg_enable = 1'b1; cfg_field_sel = 2'b11; cfg_clks_per_bit = 8'd1;
    run_line(OL, 0, 1, n, bits, hold_ok, first_ok);
    chk(bits == exp_frame(7'd0, 7'd0), "R11", "null frame after reset", bits, exp_frame(7'd0, 7'd0));

    // R1 R2 R3 sweep
    for (int en = 0; en < 2; en++)
      for (int sel = 0; sel < 4; sel++)
        for (int ev = 0; ev < 2; ev++)
          for (int ln = 0; ln < 32; ln++) begin
            cfg_enable = en[0]; cfg_field_sel = sel[1:0];
            elig = en[0] && ((ln == OL && ev == 0 && sel[0]) || (ln == EL && ev == 1 && sel[1]));
            run_line(ln, ev[0], 1, n, bits, hold_ok, first_ok);
            chk(n == (elig ? 26 : 0), "R1/R2/R3", "valid count", n, elig ? 26 : 0);
          end

    // R4 R5 R7: every character in both positions, bit 7 set on writes
    cfg_enable = 1'b1; cfg_field_sel = 2'b11;
    for (int c = 0; c < 128; c++) begin
      wr(2'd0, {1'b1, 7'(c)});
      wr(2'd1, {1'b1, 7'(127 - c)});
      run_line(OL, 0, 1, n, bits, hold_ok, first_ok);
      chk(bits == exp_frame(7'(c), 7'(127 - c)), "R4 R5", "frame bits", bits,
          exp_frame(7'(c), 7'(127 - c)));
    end

    // R8: sent pair leaves nulls; even pair stays on even field
    run_line(OL, 0, 1, n, bits, hold_ok, first_ok);
    chk(bits == exp_frame(0, 0), "R8", "odd null after send", bits, exp_frame(0, 0));
    wr(2'd2, 8'h31); wr(2'd3, 8'h52);
    run_line(OL, 0, 1, n, bits, hold_ok, first_ok);
    chk(bits == exp_frame(0, 0), "R8", "odd line ignores even pair", bits, exp_frame(0, 0));
    run_line(EL, 1, 1, n, bits, hold_ok, first_ok);
    chk(bits == exp_frame(7'h31, 7'h52), "R8 R7", "even pair", bits, exp_frame(7'h31, 7'h52));
    run_line(EL, 1, 1, n, bits, hold_ok, first_ok);
    chk(bits == exp_frame(0, 0), "R8", "even null after send", bits, exp_frame(0, 0));

    // R7: write to first slot alone does not arm
    wr(2'd0, 8'h2A);
    run_line(OL, 0, 1, n, bits, hold_ok, first_ok);
    chk(bits == exp_frame(0, 0), "R7", "char1 write not armed", bits, exp_frame(0, 0));
    wr(2'd1, 8'h15);
    run_line(OL, 0, 1, n, bits, hold_ok, first_ok);
    chk(bits == exp_frame(7'h2A, 7'h15), "R7", "char2 write arms", bits, exp_frame(7'h2A, 7'h15));

    // R6: divider sweep
    for (int d = 0; d < 6; d++) begin
      int e;
      e = (d == 0) ? 1 : d;
      cfg_clks_per_bit = 8'(d);
      wr(2'd0, 8'h47); wr(2'd1, 8'h0C);
      run_line(OL, 0, e, n, bits, hold_ok, first_ok);
      chk(n == 26 * e, "R6", "valid length", n, 26 * e);
      chk(hold_ok && first_ok, "R6", "bit hold and start cycle", {hold_ok, first_ok}, 2'b11);
      chk(bits == exp_frame(7'h47, 7'h0C), "R6", "frame under divider", bits, exp_frame(7'h47, 7'h0C));
    end

    // R9: write during transmission held
    cfg_clks_per_bit = 8'd2;
    wr(2'd0, 8'h11); wr(2'd1, 8'h22);
    fork
      run_line(OL, 0, 2, n, bits, hold_ok, first_ok);
      begin repeat (6) @(negedge clk); wr(2'd0, 8'h33); wr(2'd1, 8'h44); end
    join
    chk(bits == exp_frame(7'h11, 7'h22), "R9", "frame in flight unchanged", bits, exp_frame(7'h11, 7'h22));
    run_line(OL, 0, 2, n, bits, hold_ok, first_ok);
    chk(bits == exp_frame(7'h33, 7'h44), "R9", "held write applied", bits, exp_frame(7'h33, 7'h44));

    // R10: line start during transmission ignored
    wr(2'd2, 8'h55); wr(2'd3, 8'h66);
    fork
      run_line(OL, 0, 2, n, bits, hold_ok, first_ok);
      begin
        repeat (10) @(negedge clk);
        line_start = 1'b1; line_num = LW'(EL); field_even = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
      end
    join
    chk(n == 52 && hold_ok, "R10", "no restart", n, 52);
    run_line(EL, 1, 2, n, bits, hold_ok, first_ok);
    chk(bits == exp_frame(7'h55, 7'h66), "R10", "even pair still armed", bits, exp_frame(7'h55, 7'h66));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule